// File: doc/BRIEF.md
# Head Temperature Sense Control and Conversion Readout

This block is the digital side of a print-head temperature measurement path. A host loads a 10-bit control word one bit at a time, with a data line and a strobe. A transparent hold stage sits after the shift register. Holding its enable high makes every new shift visible at once. Pulling it low freezes the active configuration while a new word is shifted in. The active word selects which head's sense resistor receives the measurement current and whether that current source is on. It also sets a 5-bit offset code for the offset DAC and picks one of six converter input channels.

The block also returns an 8-bit conversion result over a serial line. A rising conversion-start level captures the parallel result word and enables the output driver. Each falling edge of the conversion clock moves the line to the next lower bit. The last bit stays on the line until conversion-start goes low, which releases the line to high impedance. Every strobe input is sampled on the system clock, and edges are found by comparing each sample with the previous one.

Top module: `tsense_ctl`

## Requirements
- R1: Each rising edge seen on `cr_clk` shifts `cr_data` into bit 0 of the 10-bit control register. Older bits move up one place, so after ten strobes the first bit sent sits in bit 9.
- R2: While `cr_latch` is high, the decoded outputs follow the shift register in the cycle it updates. While `cr_latch` is low, they hold the word that was visible when `cr_latch` fell, and any shifting has no effect on them.
- R3: Bit 9 of the active word drives `head_b_sel`: 0 selects head A's sense resistor and 1 selects head B's.
- R4: `src_on` is 1 only when bit 8 of the active word is 1 and `src_enable_n` is 0. The other three combinations give 0.
- R5: `dac_code` equals bits 7..3 of the active word, with bit 7 as the MSB of the code.
- R6: Bits 2..0 of the active word form a channel address. A value v from 0 to 5 sets only `chan_sel[v]` (bit 0 is the internal sense channel, bits 1..5 are the external channels). Values 6 and 7 set no bit.
- R7: One cycle after a rising edge of `conv_start`, `ad_oe` is 1 and `ad_data` carries bit 7 of the `conv_result` value sampled at that edge.
- R8: Each falling edge of `conv_clk` during a conversion moves `ad_data` one bit lower (7, 6, ... 0), one cycle after the edge is seen. After seven falls, `ad_data` stays on bit 0.
- R9: One cycle after `conv_start` is sampled low, `ad_oe` is 0, so the serial line is released.
- R10: After a synchronous reset, the control word is all zeros (head A, source off, offset 0, channel 0 selected) and `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_clk | input | 1 | Control word shift strobe |
| cr_data | input | 1 | Control word serial data |
| cr_latch | input | 1 | Hold-stage enable; high makes the stage transparent |
| src_enable_n | input | 1 | Active-low external current-source enable |
| conv_start | input | 1 | Conversion start level |
| conv_clk | input | 1 | Conversion serial clock |
| conv_result | input | 8 | Parallel result from the converter core |
| head_b_sel | output | 1 | 0 = head A resistor, 1 = head B resistor |
| src_on | output | 1 | Measurement current source on |
| dac_code | output | 5 | Offset DAC code |
| chan_sel | output | 6 | One-hot converter channel select |
| ad_data | output | 1 | Serial result bit |
| ad_oe | output | 1 | Output enable for the serial result line (0 = high impedance) |

## Verification
On every cycle, the assertions check the following: channel selects are never more than one hot, and the current source is never on while the external enable is high. They also check that the active configuration cannot move while the hold stage is closed, that the serial line is released after conversion-start falls, and that the serial bit moves only after a conversion-clock fall. The bench sweeps all 1024 control words with both enable pin levels and compares every decoded field with arithmetic expectations. Only those scenarios can show that the bit order is right, that the MSB-first serial sequence holds for many result words, and that the last bit is held.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int CR_W    = 10;
    localparam int DAC_W   = 5;
    localparam int ADDR_W  = 3;
    localparam int N_CHAN  = 6;
    localparam int RES_W   = 8;
    localparam int RCNT_W  = $clog2(RES_W);

    // Active configuration; packing order gives bit 9 down to bit 0.
    typedef struct packed {
        logic              head_b;
        logic              src_req;
        logic [DAC_W-1:0]  offset;
        logic [ADDR_W-1:0] chan;
    } cr_fields_t;

    // One-hot channel decode; addresses beyond the channel count select nothing.
    function automatic logic [N_CHAN-1:0] chan_decode(input logic [ADDR_W-1:0] a);
        logic [N_CHAN-1:0] r;
        for (int i = 0; i < N_CHAN; i++) begin
            r[i] = (a == ADDR_W'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/tsense_edge.sv
module tsense_edge #(
    parameter int N       = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] pulse
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = prev_q & ~din;
        end else begin : g_rise
            assign pulse = ~prev_q & din;
        end
    endgenerate

endmodule

// File: rtl/tsense_ctrl_reg.sv
module tsense_ctrl_reg
    import tsense_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_en,
    input  logic       sdata,
    input  logic       hold_open,
    output cr_fields_t active
);

    logic [CR_W-1:0] sr_q;
    logic [CR_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[CR_W-2:0], sdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (hold_open) begin
            held_q <= sr_q;
        end
    end

    assign active = cr_fields_t'(hold_open ? sr_q : held_q);

endmodule

// File: rtl/tsense_decode.sv
module tsense_decode
    import tsense_pkg::*;
(
    input  cr_fields_t        active,
    input  logic              src_enable_n,
    output logic              head_b_sel,
    output logic              src_on,
    output logic [DAC_W-1:0]  dac_code,
    output logic [N_CHAN-1:0] chan_sel
);

    always_comb begin
        head_b_sel = active.head_b;
        src_on     = active.src_req & ~src_enable_n;
        dac_code   = active.offset;
        chan_sel   = chan_decode(active.chan);
    end

endmodule

// File: rtl/tsense_readout.sv
module tsense_readout
    import tsense_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_lvl,
    input  logic             start_rise,
    input  logic             sclk_fall,
    input  logic [RES_W-1:0] result,
    output logic             sdo,
    output logic             sdo_oe
);

    localparam int LAST = RES_W - 1;

    logic [RES_W-1:0]  word_q;
    logic [RCNT_W-1:0] cnt_q;
    logic              active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (!start_lvl) begin
            active_q <= 1'b0;
        end else if (start_rise) begin
            word_q   <= result;
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q && sclk_fall && (cnt_q < RCNT_W'(LAST))) begin
            word_q <= {word_q[RES_W-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sdo    = word_q[RES_W-1];
    assign sdo_oe = active_q;

endmodule

// File: rtl/tsense_ctl.sv
module tsense_ctl
    import tsense_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cr_clk,
    input  logic             cr_data,
    input  logic             cr_latch,
    input  logic             src_enable_n,
    input  logic             conv_start,
    input  logic             conv_clk,
    input  logic [RES_W-1:0] conv_result,
    output logic             head_b_sel,
    output logic             src_on,
    output logic [DAC_W-1:0] dac_code,
    output logic [N_CHAN-1:0] chan_sel,
    output logic             ad_data,
    output logic             ad_oe
);

    logic [1:0] rise_vec;
    logic       sclk_fall;
    cr_fields_t active;

    tsense_edge #(.N(2), .FALLING(1'b0)) u_rise (
        .clk   (clk),
        .rst   (rst),
        .din   ({conv_start, cr_clk}),
        .pulse (rise_vec)
    );

    tsense_edge #(.N(1), .FALLING(1'b1)) u_fall (
        .clk   (clk),
        .rst   (rst),
        .din   (conv_clk),
        .pulse (sclk_fall)
    );

    tsense_ctrl_reg u_creg (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (rise_vec[0]),
        .sdata     (cr_data),
        .hold_open (cr_latch),
        .active    (active)
    );

    tsense_decode u_dec (
        .active       (active),
        .src_enable_n (src_enable_n),
        .head_b_sel   (head_b_sel),
        .src_on       (src_on),
        .dac_code     (dac_code),
        .chan_sel     (chan_sel)
    );

    tsense_readout u_rd (
        .clk        (clk),
        .rst        (rst),
        .start_lvl  (conv_start),
        .start_rise (rise_vec[1]),
        .sclk_fall  (sclk_fall),
        .result     (conv_result),
        .sdo        (ad_data),
        .sdo_oe     (ad_oe)
    );

endmodule

// File: rtl/tsense_ctl_chk.sv
module tsense_ctl_chk
    import tsense_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cr_latch,
    input logic              src_enable_n,
    input logic              conv_start,
    input logic              conv_clk,
    input logic              head_b_sel,
    input logic              src_on,
    input logic [DAC_W-1:0]  dac_code,
    input logic [N_CHAN-1:0] chan_sel,
    input logic              ad_data,
    input logic              ad_oe
);

    // R6
    chan_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_sel));

    // R4
    src_gate_chk: assert property (@(posedge clk) disable iff (rst)
        src_on |-> !src_enable_n);

    // R2
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !cr_latch |-> $stable({head_b_sel, dac_code, chan_sel}));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_start |=> !ad_oe);

    // R7
    start_oe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ad_oe) |-> $past(conv_start));

    // R8
    bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && $past(ad_oe) && !($past(conv_clk, 2) && !$past(conv_clk)))
            |-> $stable(ad_data));

endmodule

bind tsense_ctl tsense_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cr_latch     (cr_latch),
    .src_enable_n (src_enable_n),
    .conv_start   (conv_start),
    .conv_clk     (conv_clk),
    .head_b_sel   (head_b_sel),
    .src_on       (src_on),
    .dac_code     (dac_code),
    .chan_sel     (chan_sel),
    .ad_data      (ad_data),
    .ad_oe        (ad_oe)
);

// File: tb/tsense_ctl_tb.sv
module tsense_ctl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cr_clk, cr_data, cr_latch, src_enable_n;
    logic       conv_start, conv_clk;
    logic [7:0] conv_result;
    logic       head_b_sel, src_on, ad_data, ad_oe;
    logic [4:0] dac_code;
    logic [5:0] chan_sel;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsense_ctl u_dut (
        .clk          (clk),
        .rst          (rst),
        .cr_clk       (cr_clk),
        .cr_data      (cr_data),
        .cr_latch     (cr_latch),
        .src_enable_n (src_enable_n),
        .conv_start   (conv_start),
        .conv_clk     (conv_clk),
        .conv_result  (conv_result),
        .head_b_sel   (head_b_sel),
        .src_on       (src_on),
        .dac_code     (dac_code),
        .chan_sel     (chan_sel),
        .ad_data      (ad_data),
        .ad_oe        (ad_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_chan(input logic [2:0] a);
        return (a < 3'd6) ? (6'b1 << a) : 6'b0;
    endfunction

    // Sends bits 9..0 in that order (R1: first bit ends in bit 9).
    task automatic shift_word(input logic [9:0] w);
        for (int i = 9; i >= 0; i--) begin
            @(negedge clk);
            cr_data = w[i];
            cr_clk  = 1'b1;
            @(negedge clk);
            cr_clk  = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic check_word(input string tag, input logic [9:0] w);
        check({tag, " R3 head"}, 16'(head_b_sel), 16'(w[9]));
        check({tag, " R5 dac"},  16'(dac_code),   16'(w[7:3]));
        check({tag, " R6 chan"}, 16'(chan_sel),   16'(exp_chan(w[2:0])));
        src_enable_n = 1'b0; #1;
        check({tag, " R4 src pin0"}, 16'(src_on), 16'(w[8]));
        src_enable_n = 1'b1; #1;
        check({tag, " R4 src pin1"}, 16'(src_on), 16'h0);
    endtask

    task automatic conv_clk_fall;
        @(negedge clk); conv_clk = 1'b1;
        @(negedge clk); conv_clk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        cr_clk = 0; cr_data = 0; cr_latch = 1; src_enable_n = 1;
        conv_start = 0; conv_clk = 0; conv_result = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check("R10 head", 16'(head_b_sel), 16'h0);
        check("R10 dac",  16'(dac_code),   16'h0);
        check("R10 chan", 16'(chan_sel),   16'h1);
        check("R10 src",  16'(src_on),     16'h0);
        check("R10 oe",   16'(ad_oe),      16'h0);

        // R1 R2 transparent: every control word
        for (int w = 0; w < 1024; w++) begin
            shift_word(10'(w));
            check_word("R1 sweep", 10'(w));
        end

        // R2 hold: shifting with the stage closed changes nothing
        shift_word(10'h2B5);
        @(negedge clk); cr_latch = 1'b0;
        shift_word(10'h14A);
        check_word("R2 closed", 10'h2B5);
        cr_latch = 1'b1; #1;
        check_word("R2 reopened", 10'h14A);
        @(negedge clk); cr_latch = 1'b0;
        shift_word(10'h3FF);
        check_word("R2 closed again", 10'h14A);
        @(negedge clk); cr_latch = 1'b1;
        @(negedge clk);

        // R7 R8 R9 readout sweep
        for (int i = 0; i < 24; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 11) % 256);
            if (i == 22) v = 8'h00;
            if (i == 23) v = 8'hFF;
            @(negedge clk);
            conv_result = v;
            conv_start  = 1'b1;
            @(negedge clk);
            conv_result = ~v;
            check("R7 oe", 16'(ad_oe), 16'h1);
            check("R7 msb", 16'(ad_data), 16'(v[7]));
            for (int k = 1; k < 8; k++) begin
                conv_clk_fall();
                check("R8 bit", 16'(ad_data), 16'(v[7-k]));
            end
            conv_clk_fall();
            check("R8 hold lsb", 16'(ad_data), 16'(v[0]));
            conv_clk_fall();
            check("R8 hold lsb2", 16'(ad_data), 16'(v[0]));
            check("R9 oe before", 16'(ad_oe), 16'h1);
            conv_start = 1'b0;
            @(negedge clk);
            check("R9 released", 16'(ad_oe), 16'h0);
        end

        // R10 again after mid-run reset
        shift_word(10'h3C7);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check_word("R10 rerst", 10'h000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule